// File: doc/BRIEF.md
# Paged GPIO Controller with Edge Interrupts

This block is a byte-wide register-mapped controller for 48 general-purpose lines, arranged as six ports of eight lines each. A host reaches it through a simple bus with a 4-bit offset, separate read and write strobes, and 8-bit write and read data. Each port has a data register. A written 1 drives the line's output, and a written 0 releases the line so that it can be sensed. Reading a port returns the synchronized levels on the pins. The pin side is modelled as separate output and input vectors.

The first three ports can raise interrupts. Three offsets are shared between three register banks: edge polarity, edge enable and latched edge identification. A page field in a control register chooses which bank those offsets reach. The same control register carries one write-lock bit per port. The block synchronizes the input pins through two flops and then compares each line with its previous sample. An enabled edge of the chosen direction latches a bit that software clears by writing a one. A per-port summary byte reports which ports hold latched bits. A registered interrupt request is the OR of all latched bits.

Top module: `pgpio_ctrl`

## Requirements
- R1: After reset, pin_out is all zero, irq is low, the control register at offset 0x7 reads 0x00, and the three banks behind offsets 0x8, 0x9 and 0xA read 0x00 under every page.
- R2: A write to offset p (0x0 to 0x5) updates pin_out[8p+7:8p] on the next clock when that port is unlocked. bus_rdata shows the addressed register only while bus_rd is high and reads 0 otherwise. The control register reads back the value written to it.
- R3: A read of offsets 0x0 to 0x5 returns the pin_in byte of that port as it was two clock edges earlier (two-flop synchronizer). After a single edge the old level is still returned.
- R4: Control register bits 5:0 are per-port lock bits for ports 0 to 5. While a port's lock bit is 1, writes to its data offset are ignored and its output byte keeps its value.
- R5: Control register bits 7:6 pick the page: 1 is polarity, 2 is enable, 3 is edge identification. Offsets 0x8, 0x9 and 0xA reach ports 0, 1 and 2 of the chosen bank. With page 0 these offsets read 0 and ignore writes.
- R6: A line of ports 0 to 2 with polarity 1 and enable 1 latches its identification bit on a low-to-high pin transition. With polarity 1, a high-to-low transition latches nothing.
- R7: With polarity 0 and enable 1, a high-to-low transition latches the bit and a low-to-high transition does not.
- R8: A line whose enable bit is 0 latches nothing. Writing its enable bit to 0 clears its latched bit. Setting the enable bit again does not bring back a bit that was cleared.
- R9: Under page 3, a write to an identification offset clears every latched bit where the written data is 1. Data bits of 0 leave latched bits unchanged.
- R10: Offset 0x6 reads {5'b0, any latched bit in port 2, port 1, port 0} and ignores writes.
- R11: irq is high exactly one clock after any identification bit is set, and low one clock after all are cleared.
- R12: Transitions on lines 24 to 47 never latch anything and never raise irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register offset |
| bus_wr | input | 1 | Write strobe, acts on the rising clock edge |
| bus_rd | input | 1 | Read strobe, enables bus_rdata |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| pin_in | input | 48 | Pin levels as sensed, line n at bit n |
| pin_out | output | 48 | Output drive, line n at bit n |
| irq | output | 1 | Registered interrupt request, active high |

## Verification
All 24 interrupt-capable lines are swept one at a time with rising-edge polarity. Each line is raised and then lowered, which tells a correctly latched edge apart from a wrong-direction capture and from a neighbouring bit. The sweep also shows that zero-data writes leave latched bits alone and that one-data writes clear them. A second sweep holds port 1 high under falling polarity and drops each line in turn, which tells the polarity inversion apart from plain level sensing. Further patterns cover a masked line, disabling after capture and re-enabling, toggling the upper 24 lines, and writes to locked ports and under page 0. These show that none of those cases leaks into the data registers, the latched bits or irq.

// File: rtl/pgpio_pkg.sv
package pgpio_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] OFS_PEND  = 4'h6;
    localparam logic [ADDR_W-1:0] OFS_CTL   = 4'h7;
    localparam logic [ADDR_W-1:0] OFS_PAGED = 4'h8;

    typedef enum logic [1:0] {
        PG_NONE = 2'd0,
        PG_POL  = 2'd1,
        PG_ENAB = 2'd2,
        PG_ID   = 2'd3
    } page_e;

    typedef struct packed {
        page_e       page;
        logic [5:0]  lock;
    } ctl_s;

    // Per-line edge qualifier: polarity 1 -> rising, 0 -> falling.
    function automatic logic [BYTE_W-1:0] edge_hits(
        input logic [BYTE_W-1:0] cur,
        input logic [BYTE_W-1:0] prev,
        input logic [BYTE_W-1:0] pol
    );
        return (pol & cur & ~prev) | (~pol & ~cur & prev);
    endfunction

endpackage

// File: rtl/pgpio_sync.sv
module pgpio_sync #(
    parameter int W = 48
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] lvl,
    output logic [W-1:0] lvl_prev
);

    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q   <= '0;
            lvl      <= '0;
            lvl_prev <= '0;
        end else begin
            meta_q   <= d;
            lvl      <= meta_q;
            lvl_prev <= lvl;
        end
    end

endmodule

// File: rtl/pgpio_irq_bank.sv
module pgpio_irq_bank
    import pgpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] lvl,
    input  logic [BYTE_W-1:0] lvl_prev,
    input  logic              pol_we,
    input  logic              enab_we,
    input  logic              id_w1c,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] pol_q,
    output logic [BYTE_W-1:0] enab_q,
    output logic [BYTE_W-1:0] id_q
);

    logic [BYTE_W-1:0] hit;
    logic [BYTE_W-1:0] enab_d;
    logic [BYTE_W-1:0] clr;
    logic [BYTE_W-1:0] id_d;

    always_comb begin
        hit    = edge_hits(lvl, lvl_prev, pol_q) & enab_q;
        enab_d = enab_we ? wdata : enab_q;
        clr    = id_w1c ? wdata : '0;
        id_d   = ((id_q & ~clr) | hit) & enab_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pol_q  <= '0;
            enab_q <= '0;
            id_q   <= '0;
        end else begin
            if (pol_we) pol_q <= wdata;
            enab_q <= enab_d;
            id_q   <= id_d;
        end
    end

    // R8: a bit whose enable just dropped holds no latched edge
    a_r8_disable_clears: assert property (@(posedge clk) disable iff (rst)
        ((id_q & $past(enab_q) & ~enab_q) == '0));

    // R9: bits cleared by a one-write stay clear unless a new edge arrives
    a_r9_w1c_clears: assert property (@(posedge clk) disable iff (rst)
        id_w1c |=> ((id_q & $past(wdata) & ~$past(hit)) == '0));

    // R6: a qualified edge latches when nothing else touches the bank
    a_r6_capture: assert property (@(posedge clk) disable iff (rst)
        (!enab_we && !id_w1c && (hit != '0)) |=> ((id_q & $past(hit)) == $past(hit)));

    // R8: a masked line never appears in the latched bits
    a_r8_masked_quiet: assert property (@(posedge clk) disable iff (rst)
        ((id_q & ~enab_q) == '0));

endmodule

// File: rtl/pgpio_ctrl.sv
module pgpio_ctrl
    import pgpio_pkg::*;
#(
    parameter int NUM_PORTS = 6,
    parameter int IRQ_PORTS = 3
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic                          bus_wr,
    input  logic                          bus_rd,
    input  logic [BYTE_W-1:0]             bus_wdata,
    output logic [BYTE_W-1:0]             bus_rdata,
    input  logic [NUM_PORTS*BYTE_W-1:0]   pin_in,
    output logic [NUM_PORTS*BYTE_W-1:0]   pin_out,
    output logic                          irq
);

    localparam int LINES = NUM_PORTS * BYTE_W;

    ctl_s ctl_q;
    logic [LINES-1:0]     lvl, lvl_prev;
    logic [BYTE_W-1:0]    data_q [NUM_PORTS];
    logic [BYTE_W-1:0]    pol_v  [IRQ_PORTS];
    logic [BYTE_W-1:0]    enab_v [IRQ_PORTS];
    logic [BYTE_W-1:0]    id_v   [IRQ_PORTS];
    logic [IRQ_PORTS-1:0] pend;

    // control register: page select and per-port locks
    always_ff @(posedge clk) begin
        if (rst)                              ctl_q <= '0;
        else if (bus_wr && bus_addr == OFS_CTL) ctl_q <= ctl_s'(bus_wdata);
    end

    // port data registers
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        always_ff @(posedge clk) begin
            if (rst)
                data_q[p] <= '0;
            else if (bus_wr && bus_addr == ADDR_W'(p) && !ctl_q.lock[p])
                data_q[p] <= bus_wdata;
        end
        assign pin_out[p*BYTE_W +: BYTE_W] = data_q[p];

        // R4: a locked port keeps its byte across a write
        a_r4_lock_holds: assert property (@(posedge clk) disable iff (rst)
            (bus_wr && bus_addr == ADDR_W'(p) && ctl_q.lock[p])
                |=> (pin_out[p*BYTE_W +: BYTE_W] == $past(pin_out[p*BYTE_W +: BYTE_W])));
    end

    pgpio_sync #(.W(LINES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .d        (pin_in),
        .lvl      (lvl),
        .lvl_prev (lvl_prev)
    );

    // interrupt-capable ports
    for (genvar q = 0; q < IRQ_PORTS; q++) begin : g_bank
        logic sel;
        assign sel = bus_wr && (bus_addr == OFS_PAGED + ADDR_W'(q));

        pgpio_irq_bank u_bank (
            .clk      (clk),
            .rst      (rst),
            .lvl      (lvl[q*BYTE_W +: BYTE_W]),
            .lvl_prev (lvl_prev[q*BYTE_W +: BYTE_W]),
            .pol_we   (sel && ctl_q.page == PG_POL),
            .enab_we  (sel && ctl_q.page == PG_ENAB),
            .id_w1c   (sel && ctl_q.page == PG_ID),
            .wdata    (bus_wdata),
            .pol_q    (pol_v[q]),
            .enab_q   (enab_v[q]),
            .id_q     (id_v[q])
        );
        assign pend[q] = |id_v[q];
    end

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= |pend;
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            for (int p = 0; p < NUM_PORTS; p++)
                if (bus_addr == ADDR_W'(p)) bus_rdata = lvl[p*BYTE_W +: BYTE_W];
            if (bus_addr == OFS_PEND) bus_rdata[IRQ_PORTS-1:0] = pend;
            if (bus_addr == OFS_CTL)  bus_rdata = ctl_q;
            for (int q = 0; q < IRQ_PORTS; q++) begin
                if (bus_addr == OFS_PAGED + ADDR_W'(q)) begin
                    case (ctl_q.page)
                        PG_POL:  bus_rdata = pol_v[q];
                        PG_ENAB: bus_rdata = enab_v[q];
                        PG_ID:   bus_rdata = id_v[q];
                        default: bus_rdata = '0;
                    endcase
                end
            end
        end
    end

    // R11: request is the OR of latched bits, one register late
    a_r11_irq_follows: assert property (@(posedge clk) disable iff (rst)
        irq == $past(|pend));

    // R5: page 0 hides the paged banks
    a_r5_page0_quiet: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && ctl_q.page == PG_NONE && bus_addr >= OFS_PAGED
            && bus_addr < OFS_PAGED + ADDR_W'(IRQ_PORTS)) |-> (bus_rdata == '0));

    // R2: reads are silent without the strobe
    a_r2_rd_gated: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |-> (bus_rdata == '0));

endmodule

// File: tb/test_pgpio_ctrl.sv
module test_pgpio_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [47:0] pin_in = '0;
    logic [47:0] pin_out;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    pgpio_ctrl i_pgpio_ctrl (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .irq(irq)
    );

    task automatic chk(input logic ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        d = bus_rdata;
        bus_rd = 1'b0;
        #0.1;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [7:0] e;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk(pin_out == '0, "R1", pin_out, 0);
        chk(irq == 1'b0, "R1", irq, 0);
        rd(4'h7, v); chk(v == 8'h00, "R1", v, 0);
        for (int pg = 0; pg < 4; pg++) begin
            wr(4'h7, 8'(pg << 6));
            for (int q = 0; q < 3; q++) begin
                rd(4'(8 + q), v); chk(v == 8'h00, "R1", v, 0);
            end
        end
        wr(4'h7, 8'h00);

        // R2 data writes, strobe gating, control read-back
        for (int p = 0; p < 6; p++) wr(4'(p), 8'((p * 37 + 5) & 8'hFF));
        for (int p = 0; p < 6; p++)
            chk(pin_out[p*8 +: 8] == 8'((p * 37 + 5) & 8'hFF), "R2",
                pin_out[p*8 +: 8], (p * 37 + 5) & 8'hFF);
        bus_addr = 4'h7; #1;
        chk(bus_rdata == 8'h00, "R2", bus_rdata, 0);
        wr(4'h7, 8'h15); rd(4'h7, v); chk(v == 8'h15, "R2", v, 8'h15);
        wr(4'h7, 8'h00);

        // R3 two-flop synchronizer delay
        pin_in = 48'h0000_5A00_0000;
        @(negedge clk);
        rd(4'h3, v); chk(v == 8'h00, "R3", v, 0);
        @(negedge clk);
        rd(4'h3, v); chk(v == 8'h5A, "R3", v, 8'h5A);
        pin_in = '0;
        settle();
        rd(4'h3, v); chk(v == 8'h00, "R3", v, 0);

        // R4 locks
        wr(4'h7, 8'h22);
        wr(4'h1, 8'hC3); wr(4'h5, 8'hC3); wr(4'h0, 8'h99);
        chk(pin_out[15:8] == 8'd42, "R4", pin_out[15:8], 42);
        chk(pin_out[47:40] == 8'(5 * 37 + 5), "R4", pin_out[47:40], 5 * 37 + 5);
        chk(pin_out[7:0] == 8'h99, "R4", pin_out[7:0], 8'h99);
        wr(4'h7, 8'h00);
        wr(4'h1, 8'hC3);
        chk(pin_out[15:8] == 8'hC3, "R4", pin_out[15:8], 8'hC3);

        // R5 paging
        wr(4'h7, 8'h40); wr(4'h9, 8'hA5);
        wr(4'h7, 8'h80); wr(4'h9, 8'h3C);
        wr(4'h7, 8'h00); wr(4'h9, 8'hFF);
        rd(4'h9, v); chk(v == 8'h00, "R5", v, 0);
        wr(4'h7, 8'h40); rd(4'h9, v); chk(v == 8'hA5, "R5", v, 8'hA5);
        wr(4'h7, 8'h80); rd(4'h9, v); chk(v == 8'h3C, "R5", v, 8'h3C);
        rd(4'h8, v); chk(v == 8'h00, "R5", v, 0);

        // R6 / R9 / R10 / R11: rising sweep over all 24 lines
        wr(4'h7, 8'h40);
        for (int q = 0; q < 3; q++) wr(4'(8 + q), 8'hFF);
        wr(4'h7, 8'h80);
        for (int q = 0; q < 3; q++) wr(4'(8 + q), 8'hFF);
        wr(4'h7, 8'hC0);
        for (int i = 0; i < 24; i++) begin
            e = 8'(1 << (i % 8));
            pin_in[i] = 1'b1;
            settle();
            chk(irq == 1'b1, "R11", irq, 1);
            rd(4'h6, v); chk(v == 8'(1 << (i / 8)), "R10", v, 1 << (i / 8));
            rd(4'(8 + i / 8), v); chk(v == e, "R6", v, e);
            wr(4'(8 + i / 8), ~e);
            rd(4'(8 + i / 8), v); chk(v == e, "R9", v, e);
            wr(4'(8 + i / 8), e);
            rd(4'(8 + i / 8), v); chk(v == 8'h00, "R9", v, 0);
            @(negedge clk);
            chk(irq == 1'b0, "R11", irq, 0);
            pin_in[i] = 1'b0;
            settle();
            rd(4'(8 + i / 8), v); chk(v == 8'h00, "R6", v, 0);
        end

        // R7 falling sweep on port 1
        wr(4'h7, 8'h40); wr(4'h9, 8'h00); wr(4'h7, 8'hC0);
        pin_in[15:8] = 8'hFF;
        settle();
        rd(4'h9, v); chk(v == 8'h00, "R7", v, 0);
        chk(irq == 1'b0, "R7", irq, 0);
        for (int b = 0; b < 8; b++) begin
            pin_in[8 + b] = 1'b0;
            settle();
            rd(4'h9, v); chk(v == 8'(1 << b), "R7", v, 1 << b);
            wr(4'h9, 8'hFF);
        end

        // R8 masking, disable clears, re-enable does not restore
        wr(4'h7, 8'h80); wr(4'h8, 8'hFE); wr(4'h7, 8'hC0);
        pin_in[0] = 1'b1;
        settle();
        rd(4'h8, v); chk(v == 8'h00, "R8", v, 0);
        chk(irq == 1'b0, "R8", irq, 0);
        pin_in[1] = 1'b1;
        settle();
        rd(4'h8, v); chk(v == 8'h02, "R8", v, 2);
        wr(4'h7, 8'h80); wr(4'h8, 8'hFD); wr(4'h8, 8'hFF); wr(4'h7, 8'hC0);
        rd(4'h8, v); chk(v == 8'h00, "R8", v, 0);
        @(negedge clk);
        chk(irq == 1'b0, "R8", irq, 0);
        pin_in[1:0] = 2'b00;
        settle();

        // R12 upper lines never interrupt
        pin_in[47:24] = 24'hFFFFFF;
        settle();
        pin_in[47:24] = 24'h000000;
        settle();
        chk(irq == 1'b0, "R12", irq, 0);
        rd(4'h6, v); chk(v == 8'h00, "R12", v, 0);

        // R10 pending ignores writes
        pin_in[16] = 1'b1;
        settle();
        wr(4'h6, 8'hFF);
        rd(4'h6, v); chk(v == 8'h04, "R10", v, 4);
        chk(irq == 1'b1, "R10", irq, 1);
        wr(4'hA, 8'h01);
        rd(4'h6, v); chk(v == 8'h00, "R10", v, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule